// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block sits beside a small CPU core and decides which interrupt the core takes next. Seven request sources are supported: two external pins, two timer flags, a synchronous serial unit flag, and a USB endpoint flag and a USB device flag from the USB logic. An eighth source, power-down wake-up, is separate from these. Each of the seven sources has an enable bit and a priority bit, and a global enable gates them all. At an instruction boundary the block picks the winning request, raises a one-clock acknowledge, and presents the fixed 16-bit address of the winner's service routine. The core then performs a long call to that address, saving only its return address.

Two in-service flags record which priority levels are active. Only the core's return-from-interrupt strobe clears them. A plain return strobe is ignored, so requests of that level or a lower one stay blocked. The external pins can be set to edge or level mode. In edge mode, a falling edge latches a flag that the acknowledge clears. In level mode, the flag follows the pin.

A sequencer with three states handles wake-up. `ST_RUN` is normal arbitration. `ST_ARMED` is entered from `ST_RUN` when power-down mode and wake enable are both set, and it returns to `ST_RUN` if either one drops. `ST_WAKE` is entered from `ST_ARMED` when external pin 0 is low and the oscillator reports that it is ready. The sequencer leaves `ST_WAKE` for `ST_RUN` on the return strobe. Entering `ST_WAKE` issues the wake-up vector, and every other source stays masked until that return.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Vectors by source index: 0 ext0 0x0003, 1 timer0 0x000B, 2 ext1 0x0013, 3 timer1 0x001B, 4 serial 0x0043, 5 USB endpoint 0x004B, 6 USB device 0x0053, wake-up 0x007B. `vector` holds the last acknowledged address (0 after reset).
- R2: A source takes part in arbitration only when `glb_en` and its bit of `src_en` (bit = source index) are both 1.
- R3: `src_hi` bit 1 puts a source at the high level. An acknowledge sets the in-service flag of the winner's level. A high request is taken only while `insvc_hi` is 0. A low request is taken only while both in-service flags are 0.
- R4: The high level beats the low level. Within one level, the lowest source index wins.
- R5: `ack` rises on the clock edge at which `insn_bound` is sampled 1 with a takeable request in `ST_RUN`. It lasts exactly one cycle and is never high in two consecutive cycles.
- R6: With `extN_edge`=1, a falling edge of `extN_pin_n` sets `extN_flag`, and acknowledging that source clears it. A new edge in the same cycle wins over the clear. With `extN_edge`=0, `extN_flag` is the inverted pin, registered, and an acknowledge does not clear it.
- R7: The timer, serial and USB request inputs are plain levels. A request still held after the return is taken again.
- R8: In `ST_RUN`, `reti_strobe` clears `insvc_hi` if it is set, and otherwise clears `insvc_lo`. `ret_strobe` changes no in-service flag.
- R9: Arbitration uses the request values of the boundary cycle itself. A higher request raised in that cycle is vectored instead of a lower one pending earlier.
- R10: The wake-up vector 0x007B is issued only from `ST_ARMED`, which requires `pd_mode`=1 and `wake_en`=1. It fires when `ext0_pin_n`=0 and `osc_ready`=1, with no instruction boundary needed. No normal acknowledge occurs while armed.
- R11: In `ST_WAKE`, no acknowledge is given. A `reti_strobe` there returns to `ST_RUN` and leaves the level flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext0_pin_n | input | 1 | External request pin 0, active low |
| ext1_pin_n | input | 1 | External request pin 1, active low |
| ext0_edge | input | 1 | 1 = pin 0 is edge-triggered, 0 = level |
| ext1_edge | input | 1 | 1 = pin 1 is edge-triggered, 0 = level |
| tmr0_req | input | 1 | Timer 0 overflow request |
| tmr1_req | input | 1 | Timer 1 overflow request |
| ser_req | input | 1 | Serial unit request |
| usbep_req | input | 1 | USB endpoint request |
| usbdev_req | input | 1 | USB device request |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 7 | Per-source enable, bit = source index |
| src_hi | input | 7 | Per-source high-priority select |
| insn_bound | input | 1 | Core is at an instruction boundary |
| reti_strobe | input | 1 | Core executed return-from-interrupt |
| ret_strobe | input | 1 | Core executed a plain return |
| pd_mode | input | 1 | Device is in power-down |
| wake_en | input | 1 | Wake-up from power-down enabled |
| osc_ready | input | 1 | Oscillator start-up finished |
| ack | output | 1 | One-cycle acknowledge |
| vector | output | 16 | Service routine address |
| ext0_flag | output | 1 | External 0 request flag |
| ext1_flag | output | 1 | External 1 request flag |
| insvc_hi | output | 1 | High level in service |
| insvc_lo | output | 1 | Low level in service |

## Verification
The assertions assume that the core issues a return strobe only while a level or the wake-up routine is in service. They also assume that `reti_strobe` and `ret_strobe` never arrive together, and that the core never raises a return strobe in the same cycle as an acknowledge. The stimulus respects this. Every return pulse follows a drained acknowledge, and boundaries and return pulses are driven in separate cycles. Inputs change only on the falling clock edge. Requests that are not part of the current step are lowered before the next step starts, so each expected vector follows from the requirements alone.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC = 7;
    localparam int VW   = 16;
    localparam logic [VW-1:0] WAKE_VEC = 16'h007B;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ARMED = 2'd1,
        ST_WAKE  = 2'd2
    } seq_st_t;

    // Sources 0..3 sit 8 bytes apart from 0x0003; sources 4..6 from 0x0043.
    function automatic logic [VW-1:0] src_vector(input int idx);
        if (idx < 4) return VW'(3 + 8 * idx);
        return VW'(16'h0043 + 8 * (idx - 4));
    endfunction
endpackage

// File: rtl/vic_ext_flag.sv
module vic_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    logic prev_q;
    logic fall;

    assign fall = prev_q & ~pin_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            flag   <= 1'b0;
        end else begin
            prev_q <= pin_n;
            if (edge_mode) begin
                if (fall)     flag <= 1'b1;
                else if (clr) flag <= 1'b0;
            end else begin
                flag <= ~pin_n;
            end
        end
    end

    // R6: acknowledge clears an edge flag when no new edge arrives
    p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr && !fall) |=> !flag);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  hi_sel,
    input  logic          insvc_hi,
    input  logic          insvc_lo,
    output logic          win_valid,
    output logic [IW-1:0] win_idx,
    output logic          win_hi
);
    logic          hi_found, lo_found;
    logic [IW-1:0] hi_idx, lo_idx;

    always_comb begin
        hi_found = 1'b0;
        lo_found = 1'b0;
        hi_idx   = '0;
        lo_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && hi_sel[i]) begin
                hi_found = 1'b1;
                hi_idx   = IW'(i);
            end
            if (req[i] && !hi_sel[i]) begin
                lo_found = 1'b1;
                lo_idx   = IW'(i);
            end
        end
        win_valid = 1'b0;
        win_hi    = 1'b0;
        win_idx   = '0;
        if (hi_found && !insvc_hi) begin
            win_valid = 1'b1;
            win_hi    = 1'b1;
            win_idx   = hi_idx;
        end else if (lo_found && !insvc_hi && !insvc_lo) begin
            win_valid = 1'b1;
            win_idx   = lo_idx;
        end
    end

    // R3: a low winner only when no level is in service
    p_lo_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !win_hi) |-> (!insvc_hi && !insvc_lo));
    // R3: a high winner only when the high level is free
    p_hi_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_hi) |-> !insvc_hi);
    // R4: the winner is a requesting source of the chosen level
    p_win_real_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req[win_idx] && (hi_sel[win_idx] == win_hi)));
endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int N  = 7,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_valid,
    input  logic [IW-1:0] win_idx,
    input  logic          win_hi,
    input  logic          insn_bound,
    input  logic          reti_strobe,
    input  logic          ret_strobe,
    input  logic          pd_mode,
    input  logic          wake_en,
    input  logic          osc_ready,
    input  logic          ext0_pin_n,
    output logic          ack,
    output logic [VW-1:0] vector,
    output logic [N-1:0]  ack_src,
    output logic          insvc_hi,
    output logic          insvc_lo
);
    seq_st_t state, nxt;
    logic    arm, wake_go, fire, reti_lvl;

    assign arm      = pd_mode & wake_en;
    assign wake_go  = (state == ST_ARMED) & arm & ~ext0_pin_n & osc_ready;
    assign fire     = (state == ST_RUN) & ~arm & insn_bound & win_valid & ~ack;
    assign reti_lvl = (state == ST_RUN) & reti_strobe;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (arm) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!arm)         nxt = ST_RUN;
                else if (wake_go) nxt = ST_WAKE;
            end
            ST_WAKE:  if (reti_strobe) nxt = ST_RUN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            vector   <= '0;
            ack_src  <= '0;
            insvc_hi <= 1'b0;
            insvc_lo <= 1'b0;
        end else begin
            ack     <= fire | wake_go;
            ack_src <= fire ? (N'(1) << win_idx) : '0;
            if (fire)         vector <= src_vector(int'(win_idx));
            else if (wake_go) vector <= WAKE_VEC;
            if (reti_lvl) begin
                if (insvc_hi) insvc_hi <= 1'b0;
                else          insvc_lo <= 1'b0;
            end
            if (fire) begin
                if (win_hi) insvc_hi <= 1'b1;
                else        insvc_lo <= 1'b1;
            end
        end
    end

    // R5: acknowledge is a single-cycle pulse
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R11: no acknowledge after the wake entry while the wake routine runs
    p_wake_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && $past(state) == ST_WAKE) |-> !ack);
    // R10: entering the wake state presents the wake vector
    p_wake_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && $past(state) == ST_ARMED) |-> (ack && vector == WAKE_VEC));
    // R8: a plain return leaves both level flags alone
    p_ret_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_strobe && !reti_strobe && !fire) |=>
        (insvc_hi == $past(insvc_hi) && insvc_lo == $past(insvc_lo)));
    // R3: a normal acknowledge always leaves a level in service
    p_level_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vector != WAKE_VEC) |-> (insvc_hi || insvc_lo));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext0_pin_n,
    input  logic            ext1_pin_n,
    input  logic            ext0_edge,
    input  logic            ext1_edge,
    input  logic            tmr0_req,
    input  logic            tmr1_req,
    input  logic            ser_req,
    input  logic            usbep_req,
    input  logic            usbdev_req,
    input  logic            glb_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_hi,
    input  logic            insn_bound,
    input  logic            reti_strobe,
    input  logic            ret_strobe,
    input  logic            pd_mode,
    input  logic            wake_en,
    input  logic            osc_ready,
    output logic            ack,
    output logic [VW-1:0]   vector,
    output logic            ext0_flag,
    output logic            ext1_flag,
    output logic            insvc_hi,
    output logic            insvc_lo
);
    localparam int IW   = $clog2(NSRC);
    localparam int NEXT = 2;

    logic [NEXT-1:0] pin_n, edge_m, clr, flg;
    logic [NSRC-1:0] raw, req, ack_src;
    logic            win_valid, win_hi;
    logic [IW-1:0]   win_idx;

    assign pin_n  = {ext1_pin_n, ext0_pin_n};
    assign edge_m = {ext1_edge, ext0_edge};
    assign clr    = {ack_src[2], ack_src[0]};

    generate
        for (genvar g = 0; g < NEXT; g++) begin : g_ext
            vic_ext_flag u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_n    (pin_n[g]),
                .edge_mode(edge_m[g]),
                .clr      (clr[g]),
                .flag     (flg[g])
            );
        end
    endgenerate

    assign ext0_flag = flg[0];
    assign ext1_flag = flg[1];
    assign raw = {usbdev_req, usbep_req, ser_req, tmr1_req, flg[1], tmr0_req, flg[0]};
    assign req = raw & src_en & {NSRC{glb_en}};

    vic_arbiter #(.N(NSRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .hi_sel   (src_hi),
        .insvc_hi (insvc_hi),
        .insvc_lo (insvc_lo),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .win_hi   (win_hi)
    );

    vic_seq #(.N(NSRC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_hi     (win_hi),
        .insn_bound (insn_bound),
        .reti_strobe(reti_strobe),
        .ret_strobe (ret_strobe),
        .pd_mode    (pd_mode),
        .wake_en    (wake_en),
        .osc_ready  (osc_ready),
        .ext0_pin_n (ext0_pin_n),
        .ack        (ack),
        .vector     (vector),
        .ack_src    (ack_src),
        .insvc_hi   (insvc_hi),
        .insvc_lo   (insvc_lo)
    );
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ext0_pin_n = 1'b1, ext1_pin_n = 1'b1, ext0_edge = 1'b0, ext1_edge = 1'b0;
    logic tmr0_req = 1'b0, tmr1_req = 1'b0, ser_req = 1'b0, usbep_req = 1'b0, usbdev_req = 1'b0;
    logic glb_en = 1'b0;
    logic [6:0] src_en = '0, src_hi = '0;
    logic insn_bound = 1'b0, reti_strobe = 1'b0, ret_strobe = 1'b0;
    logic pd_mode = 1'b0, wake_en = 1'b0, osc_ready = 1'b0;
    logic ack, ext0_flag, ext1_flag, insvc_hi, insvc_lo;
    logic [15:0] vector;

    int checks = 0, fails = 0;
    logic [15:0] expq[$];
    logic prev_ack = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vec_irq_ctrl dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every acknowledge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ack) begin
                if (expq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2/R3/R11 unexpected ack actual=%0h expected=none", vector);
                end else begin
                    chk("R1 R4 vector", {16'h0, vector}, {16'h0, expq.pop_front()});
                end
                if (prev_ack) begin
                    checks++; fails++;
                    $display("FAIL R5 ack width actual=2+ expected=1");
                end
            end
            prev_ack = ack;
        end
    end

    task automatic boundary(input logic [15:0] v, input bit want);
        @(negedge clk) insn_bound = 1'b1;
        if (want) expq.push_back(v);
        @(negedge clk) insn_bound = 1'b0;
    endtask

    task automatic settle(input string tag);
        repeat (2) @(negedge clk);
        chk(tag, expq.size(), 0);
    endtask

    task automatic do_reti();
        @(negedge clk) reti_strobe = 1'b1;
        @(negedge clk) reti_strobe = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        checks++; fails++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset ack", ack, 0);
        chk("R1 reset vector", vector, 0);
        chk("R3 reset levels", {insvc_hi, insvc_lo}, 0);
        chk("R6 reset flags", {ext0_flag, ext1_flag}, 0);

        // R2 gating, R7 level requests stay pending
        ser_req = 1'b1; glb_en = 1'b1;
        boundary(0, 0); settle("R2 src disabled");
        src_en = 7'b0010000; glb_en = 1'b0;
        boundary(0, 0); settle("R2 global disabled");
        glb_en = 1'b1;
        boundary(16'h0043, 1); settle("R2 both enabled");
        chk("R3 low level set", {insvc_hi, insvc_lo}, 2'b01);
        do_reti();
        chk("R8 reti clears low", {insvc_hi, insvc_lo}, 2'b00);
        boundary(16'h0043, 1); settle("R7 serial retaken");
        ser_req = 1'b0; do_reti();

        // R4 polling order and R3 blocking within the low level
        src_en = 7'b1001010;
        tmr0_req = 1'b1; tmr1_req = 1'b1; usbdev_req = 1'b1;
        boundary(16'h000B, 1); settle("R4 lowest index");
        boundary(0, 0); settle("R3 low blocks low");
        tmr0_req = 1'b0; do_reti();
        boundary(16'h001B, 1); settle("R4 next index");
        tmr1_req = 1'b0; do_reti();
        boundary(16'h0053, 1); settle("R4 last index");
        usbdev_req = 1'b0; do_reti();
        src_en = 7'b0100010; src_hi = 7'b0100000;
        tmr0_req = 1'b1; usbep_req = 1'b1;
        boundary(16'h004B, 1); settle("R4 high beats low");
        boundary(0, 0); settle("R3 high blocks low");
        usbep_req = 1'b0; do_reti();
        boundary(16'h000B, 1); settle("R3 low after high return");
        tmr0_req = 1'b0; do_reti();

        // R3 nesting and R8 plain return
        src_en = 7'b0101000;
        tmr1_req = 1'b1;
        boundary(16'h001B, 1); settle("R3 low taken");
        tmr1_req = 1'b0; usbep_req = 1'b1;
        boundary(16'h004B, 1); settle("R3 high nests");
        boundary(0, 0); settle("R3 high blocks high");
        @(negedge clk) ret_strobe = 1'b1;
        @(negedge clk) ret_strobe = 1'b0;
        chk("R8 plain return ignored", {insvc_hi, insvc_lo}, 2'b11);
        boundary(0, 0); settle("R8 still blocked");
        usbep_req = 1'b0; do_reti();
        chk("R8 reti clears high first", {insvc_hi, insvc_lo}, 2'b01);
        do_reti();
        chk("R8 reti clears low", {insvc_hi, insvc_lo}, 2'b00);

        // R6 edge and level external flags
        src_en = 7'b0000001; src_hi = '0; ext0_edge = 1'b1;
        @(negedge clk) ext0_pin_n = 1'b0;
        @(negedge clk) ext0_pin_n = 1'b1;
        @(negedge clk);
        chk("R6 edge flag set", ext0_flag, 1);
        boundary(16'h0003, 1); settle("R6 ext0 vector");
        chk("R6 edge flag cleared", ext0_flag, 0);
        do_reti();
        src_en = 7'b0000100; ext1_edge = 1'b0;
        ext1_pin_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 level flag set", ext1_flag, 1);
        boundary(16'h0013, 1); settle("R6 ext1 vector");
        chk("R6 level flag kept", ext1_flag, 1);
        ext1_pin_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 level flag follows pin", ext1_flag, 0);
        do_reti();

        // R9 late higher request at the boundary cycle
        src_en = 7'b1001000; src_hi = 7'b1000000; tmr1_req = 1'b1;
        @(negedge clk);
        insn_bound = 1'b1; usbdev_req = 1'b1; expq.push_back(16'h0053);
        @(negedge clk);
        insn_bound = 1'b0; usbdev_req = 1'b0;
        settle("R9 late high wins");
        do_reti();
        boundary(16'h001B, 1); settle("R9 low afterwards");
        tmr1_req = 1'b0; do_reti();

        // R10 wake arming and R11 masking
        src_en = 7'b0000010; src_hi = 7'b0000010;
        pd_mode = 1'b1; osc_ready = 1'b1; ext0_pin_n = 1'b0;
        settle("R10 not armed without enable");
        ext0_pin_n = 1'b1; wake_en = 1'b1; osc_ready = 1'b0;
        repeat (2) @(negedge clk);
        ext0_pin_n = 1'b0;
        settle("R10 waits for oscillator");
        @(negedge clk) osc_ready = 1'b1; expq.push_back(16'h007B);
        settle("R10 wake vector");
        ext0_pin_n = 1'b1; pd_mode = 1'b0; wake_en = 1'b0;
        tmr0_req = 1'b1;
        boundary(0, 0); settle("R11 masked in wake");
        chk("R11 levels untouched", {insvc_hi, insvc_lo}, 2'b00);
        do_reti();
        boundary(16'h000B, 1); settle("R11 unmasked after return");
        tmr0_req = 1'b0; do_reti();

        repeat (3) @(negedge clk);
        done = 1'b1;
        chk("R5 scoreboard drained", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule